// File: doc/BRIEF.md
# Per-Group Read Resynchronisation Phase Calibrator

This controller picks, separately for every data-strobe group of a memory read path, the resynchronisation setting that leaves the widest timing margin. A setting is one read-levelling delay tap together with one coarse reconfigurable clock phase. Both are carried as a single linear index `{phase, tap}`, with the tap in the low `TAP_BITS` bits. The controller is started only after the training patterns have been written to memory, because it reads those patterns back.

For each group, the controller walks every setting in increasing linear order. At each setting it asks the clock-phase logic to move and waits for that move to be acknowledged. It then asks a read-compare engine to read back the patterns and takes the pass or fail verdict. While it walks, it tracks the longest run of consecutive passing settings. It stores the middle of that run as the group's result and applies it through one more phase move. It then goes on to the next group. A group with no passing setting raises its own error flag. A single-cycle done pulse closes the whole calibration.

Top module: `rsync_phase_cal`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `step_req_o` and `chk_req_o` are 0, and all results and error flags are 0.
- R2: A `start_i` pulse while idle raises `busy_o` on the next cycle and clears all results and error flags. A `start_i` pulse while busy is ignored and has no effect on the sweep order or the results.
- R3: Within a group, every setting from index 0 to `((NUM_PHASES-1)<<TAP_BITS)|(2**TAP_BITS-1)` is presented exactly once, in increasing order. `phase_o` is the high field of the index and `tap_o` is the low `TAP_BITS` bits.
- R4: `step_req_o` stays high with a stable setting until `step_ack_i` is sampled high. A read check (`chk_req_o`) starts only in the cycle after an acknowledged step, and it stays high until `chk_done_i` is sampled high.
- R5: A group's result is `start + (len-1)/2`, using integer division. Here `start` and `len` describe the longest run of consecutive passing indices. When two runs have the same length, the earlier run is used.
- R6: A group with no passing setting gets its `err_o` bit set and a result of 0. The bit stays set until the next accepted start, and the block moves on to the next group.
- R7: After its sweep, each group gets one further step handshake that carries its result setting, or 0 when the group failed. This happens before the next group's sweep begins.
- R8: `done_o` is a one-cycle pulse. It is raised in the cycle after the last group's final step is acknowledged, and `busy_o` falls in that same cycle.
- R9: `group_o` shows the number of the group whose sweep or final step is in progress. Groups are handled in increasing order from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin calibration (write training must be complete) |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| group_o | output | GW | Group being calibrated |
| phase_o | output | PW | Coarse clock phase requested |
| tap_o | output | TAP_BITS | Delay-chain tap requested |
| step_req_o | output | 1 | Setting-change request |
| step_ack_i | input | 1 | Setting change completed |
| chk_req_o | output | 1 | Read-back check request |
| chk_done_i | input | 1 | Check verdict valid |
| chk_pass_i | input | 1 | Check verdict, 1 means the patterns matched |
| result_o | output | NUM_GROUPS*IW | Chosen index per group, group g at bits [g*IW +: IW] |
| err_o | output | NUM_GROUPS | Sticky per-group no-pass flag |

## Verification
A step request appears one cycle after the block enters a setting, and its acknowledge is acted on at the next clock edge. A read request follows one cycle after the acknowledge, and the next step request follows one cycle after the verdict. A group's result and error flag are written one cycle after its last verdict, which is before that group's final step request. The bench's responders answer one cycle after each request, so that waiting is exercised. The bench logs each handshake at the falling edge, where the acknowledge is visible, and reads results and flags at the falling edge after `done_o` is seen high. It confirms that `done_o` is low again one falling edge later.

// File: rtl/rsync_phase_cal.sv
module rsync_phase_cal #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_PHASES = 8,
  parameter int TAP_BITS   = 3,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int PW = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1,
  localparam int IW = PW + TAP_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [GW-1:0]            group_o,
  output logic [PW-1:0]            phase_o,
  output logic [TAP_BITS-1:0]      tap_o,
  output logic                     step_req_o,
  input  logic                     step_ack_i,
  output logic                     chk_req_o,
  input  logic                     chk_done_i,
  input  logic                     chk_pass_i,
  output logic [NUM_GROUPS*IW-1:0] result_o,
  output logic [NUM_GROUPS-1:0]    err_o
);
  localparam int LW = IW + 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(((NUM_PHASES - 1) << TAP_BITS) | ((1 << TAP_BITS) - 1));
  localparam logic [GW-1:0] LAST_GRP = GW'(NUM_GROUPS - 1);

  typedef enum logic [2:0] {S_IDLE, S_SET, S_CHK, S_DECIDE, S_APPLY} state_t;
  state_t state_q;

  logic [GW-1:0]            grp_q;
  logic [IW-1:0]            idx_q, run_start_q, best_start_q;
  logic [LW-1:0]            run_len_q, best_len_q;
  logic [NUM_GROUPS*IW-1:0] res_q;
  logic [NUM_GROUPS-1:0]    err_q;
  logic                     done_q;

  logic [LW-1:0] run_len_nx;
  logic [IW-1:0] run_start_nx, mid;

  assign run_len_nx   = chk_pass_i ? run_len_q + 1'b1 : '0;
  assign run_start_nx = (run_len_q == '0) ? idx_q : run_start_q;
  assign mid          = best_start_q + IW'((best_len_q - 1'b1) >> 1);

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign group_o    = grp_q;
  assign {phase_o, tap_o} = idx_q;
  assign step_req_o = (state_q == S_SET) || (state_q == S_APPLY);
  assign chk_req_o  = (state_q == S_CHK);
  assign result_o   = res_q;
  assign err_o      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      grp_q        <= '0;
      idx_q        <= '0;
      run_start_q  <= '0;
      run_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
      res_q        <= '0;
      err_q        <= '0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q     <= S_SET;
          grp_q       <= '0;
          idx_q       <= '0;
          run_len_q   <= '0;
          best_len_q  <= '0;
          res_q       <= '0;
          err_q       <= '0;
        end
        S_SET: if (step_ack_i) state_q <= S_CHK;
        S_CHK: if (chk_done_i) begin
          run_len_q   <= run_len_nx;
          run_start_q <= run_start_nx;
          if (chk_pass_i && run_len_nx > best_len_q) begin
            best_len_q   <= run_len_nx;
            best_start_q <= run_start_nx;
          end
          if (idx_q == LAST_IDX) state_q <= S_DECIDE;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_SET;
          end
        end
        S_DECIDE: begin
          if (best_len_q == '0) begin
            err_q[grp_q]            <= 1'b1;
            res_q[grp_q*IW +: IW]   <= '0;
            idx_q                   <= '0;
          end else begin
            res_q[grp_q*IW +: IW]   <= mid;
            idx_q                   <= mid;
          end
          state_q <= S_APPLY;
        end
        S_APPLY: if (step_ack_i) begin
          if (grp_q == LAST_GRP) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            grp_q      <= grp_q + 1'b1;
            idx_q      <= '0;
            run_len_q  <= '0;
            best_len_q <= '0;
            state_q    <= S_SET;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_step_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o && !step_ack_i |=> step_req_o && $stable({group_o, phase_o, tap_o}));
  assert_chk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req_o && !chk_done_i |=> chk_req_o);
  assert_chk_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_req_o) |-> $past(step_ack_i) && $past(step_req_o));
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_req_o && chk_req_o));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> (err_o & $past(err_o)) == $past(err_o));
endmodule

// File: tb/rsync_phase_cal_tb.sv
module rsync_phase_cal_tb_top;
  localparam int NG = 3, NP = 3, TB = 2, IW = 4, NS = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, step_req, chk_req;
  logic step_ack = 1'b0, chk_done = 1'b0, chk_pass = 1'b0;
  logic [1:0] grp, ph;
  logic [TB-1:0] tap;
  logic [NG*IW-1:0] result;
  logic [NG-1:0] err;

  always #4 clk = ~clk;

  rsync_phase_cal #(.NUM_GROUPS(NG), .NUM_PHASES(NP), .TAP_BITS(TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .group_o(grp), .phase_o(ph), .tap_o(tap), .step_req_o(step_req),
    .step_ack_i(step_ack), .chk_req_o(chk_req), .chk_done_i(chk_done),
    .chk_pass_i(chk_pass), .result_o(result), .err_o(err));

  logic [NS-1:0] masks [NG];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int mon_grp, mon_cnt, order_bad, apply_bad;
  logic [3:0] exp_res [NG];
  logic       exp_err [NG];

  always @(posedge clk) begin
    step_ack <= step_req && !step_ack;
    chk_done <= chk_req && !chk_done;
    chk_pass <= (grp < 2'(NG)) ? masks[grp][{ph, tap}] : 1'b0;
  end

  always @(negedge clk) if (step_req && step_ack) begin
    if (mon_cnt < NS) begin
      if ({ph, tap} != 4'(mon_cnt) || int'(grp) != mon_grp) order_bad++;
      mon_cnt++;
    end else begin
      if ({ph, tap} != exp_res[mon_grp] || int'(grp) != mon_grp) apply_bad++;
      mon_grp++;
      mon_cnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input logic [NS-1:0] m, output logic [3:0] ch, output logic e);
    int cl = 0, cs = 0, bl = 0, bs = 0;
    for (int i = 0; i < NS; i++) begin
      if (m[i]) begin
        if (cl == 0) cs = i;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    e  = (bl == 0);
    ch = e ? 4'd0 : 4'(bs + (bl - 1) / 2);
  endtask

  task automatic run(input logic [NS-1:0] m0, m1, m2, input bit poke);
    int w = 0;
    masks[0] = m0; masks[1] = m1; masks[2] = m2;
    for (int g = 0; g < NG; g++) model(masks[g], exp_res[g], exp_err[g]);
    mon_grp = 0; mon_cnt = 0; order_bad = 0; apply_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1 && err == '0, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (37) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done && w < 5000) begin @(negedge clk); w++; end
    check(done == 1'b1, "R8 done seen", int'(done), 1);
    check(busy == 1'b0, "R8 busy falls with done", int'(busy), 0);
    check(order_bad == 0, poke ? "R2 ignored start keeps order" : "R3 sweep order", order_bad, 0);
    check(apply_bad == 0 && mon_grp == NG, "R7 R9 final step per group", mon_grp, NG);
    for (int g = 0; g < NG; g++) begin
      check(result[g*IW +: IW] == exp_res[g], "R5 chosen setting",
            int'(result[g*IW +: IW]), int'(exp_res[g]));
      check(err[g] == exp_err[g], "R6 no-pass flag", int'(err[g]), int'(exp_err[g]));
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    check(step_req == 1'b0 && chk_req == 1'b0, "R8 quiet after done", int'(step_req), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int g = 0; g < NG; g++) masks[g] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !step_req && !chk_req, "R1 idle after reset", int'(busy), 0);
    check(result == '0 && err == '0, "R1 outputs clear", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(12'b000011110000, 12'b000000000000, 12'hFFF, 1'b0);
    run(12'b001110000111, 12'b100000000000, 12'b000000000001, 1'b0);
    run(12'b111100000111, 12'b010101010101, 12'b011111111110, 1'b1);
    run(12'b000000000000, 12'b000000000000, 12'b000001100000, 1'b0);
    for (int r = 0; r < 40; r++) begin
      logic [NS-1:0] a, b, c;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); a = s[11:0];
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); b = s[11:0] | s[23:12];
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); c = s[11:0] & s[23:12];
      run(a, b, c, r[2]);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule